// File: doc/BRIEF.md
# Register ALU with Carry Flag

This block is the arithmetic and logic stage of a small 32-bit controller core. Each cycle it receives a first source value, a second source register value, an 8-bit immediate and an operation code. It forms a result combinationally and keeps one carry bit in a register. A select bit chooses the second operand: either the register value, or the immediate zero-extended to 32 bits.

The result can be 8, 16 or 32 bits wide. The result is cut to the chosen width. The carry is read from the bit just above that width in the full-precision arithmetic. On subtraction the carry means a borrow took place. The carry register loads only when the strobe is high and the operation is arithmetic. Register storage, branching and memory access belong to other blocks.

Top module: `cflag_alu`

## Requirements
- R1: When `imm_sel` is 1, the second operand is `imm8` zero-extended to 32 bits. When `imm_sel` is 0, the second operand is `src2`.
- R2: Opcode 4'd0 (add) gives A+B. The new carry is bit W of the unbounded sum, where W is the selected destination width.
- R3: Opcode 4'd1 (add with carry) gives A+B+C, where C is the present carry. The new carry is bit W of that unbounded sum.
- R4: Opcode 4'd2 (subtract) gives A-B. The new carry is bit W of the two's-complement difference, so it is 1 on a borrow.
- R5: Opcode 4'd3 (subtract with carry) gives A-B-C. The new carry is bit W of that difference.
- R6: Opcode 4'd4 gives B-A and opcode 4'd5 gives B-A-C. The carry for both is bit W of the difference.
- R7: Opcode 4'd6 shifts A left and opcode 4'd7 shifts A right, both logically. The shift amount is the low 5 bits of B.
- R8: Opcode 4'd8 returns the unsigned minimum of A and B. Opcode 4'd9 returns the unsigned maximum. Both compare the full 32-bit operands before the result is truncated.
- R9: Opcode 4'd10 clears and opcode 4'd11 sets bit number B[4:0] of A. All other bits of A pass through unchanged.
- R10: `dst_w` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 select 32 bits. Result bits above the width are 0.
- R11: Opcodes 4'd6 to 4'd15 leave the carry unchanged even when strobed. Opcodes 4'd12 to 4'd15 give a result of 0.
- R12: The carry resets to 0. It changes only at a clock edge where `op_valid` is 1. The result always uses the present carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that lets the carry register load |
| opcode | input | 4 | Operation code |
| imm_sel | input | 1 | Selects the immediate as the second operand |
| src1 | input | 32 | First operand A |
| src2 | input | 32 | Second source register |
| imm8 | input | 8 | Immediate value |
| dst_w | input | 2 | Destination width code |
| result | output | 32 | Truncated result |
| carry | output | 1 | Registered carry flag |

## Verification
The hardest case to reach is a carry taken at a narrow width when the wider operand bits are not zero. For example, 0x1FF + 1 at 8 bits must give carry 0, because bit 8 of 0x200 is clear. The stimulus applies such operands directly. The with-carry and reverse forms depend on the flag left by the previous operation. The bench therefore runs ordered chains: one operation sets or clears the carry, and the next consumes it. Further chains set the carry, then issue strobed shift, min/max, bit and unused opcodes, and confirm the flag survives them.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_RSB  = 4'd4,
        OP_RSC  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_MIN  = 4'd8,
        OP_MAX  = 4'd9,
        OP_BCLR = 4'd10,
        OP_BSET = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic carry;
    } alu_state_t;

    function automatic logic is_arith(alu_op_e op);
        return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC};
    endfunction
endpackage

// File: rtl/alu_op2_sel.sv
module alu_op2_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] op2
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        op2 = imm_sel ? {{PAD_W{1'b0}}, imm_val} : reg_val;
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic [1:0]        dw,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W:0]  wide;
    logic [DATA_W:0]  ax;
    logic [DATA_W:0]  bx;
    logic [DATA_W:0]  cx;
    logic [IDX_W-1:0] cidx;

    always_comb begin
        ax = {1'b0, a};
        bx = {1'b0, b};
        cx = {{DATA_W{1'b0}}, cin};
        unique case (op)
            OP_ADD:  wide = ax + bx;
            OP_ADC:  wide = ax + bx + cx;
            OP_SUB:  wide = ax - bx;
            OP_SBC:  wide = ax - bx - cx;
            OP_RSB:  wide = bx - ax;
            OP_RSC:  wide = bx - ax - cx;
            default: wide = '0;
        endcase
        case (dw)
            2'b00:   cidx = IDX_W'(DATA_W / 4);
            2'b01:   cidx = IDX_W'(DATA_W / 2);
            default: cidx = IDX_W'(DATA_W);
        endcase
        res  = wide[DATA_W-1:0];
        cout = wide[cidx];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   amt;
    logic [DATA_W-1:0] onehot;

    always_comb begin
        amt    = b[SH_W-1:0];
        onehot = {{(DATA_W-1){1'b0}}, 1'b1} << amt;
        case (op)
            OP_SHL:  res = a << amt;
            OP_SHR:  res = a >> amt;
            OP_MIN:  res = (a < b) ? a : b;
            OP_MAX:  res = (a > b) ? a : b;
            OP_BCLR: res = a & ~onehot;
            OP_BSET: res = a | onehot;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/cflag_alu.sv
module cflag_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm8,
    input  logic [1:0]        dst_w,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    localparam int NARROW_W = DATA_W / 4;
    localparam int MID_W    = DATA_W / 2;
    localparam int SH_W     = $clog2(DATA_W);

    alu_op_e           op;
    logic [DATA_W-1:0] op2;
    logic [DATA_W-1:0] au_res;
    logic [DATA_W-1:0] lu_res;
    logic              au_cout;
    logic [DATA_W-1:0] sel_res;
    logic [DATA_W-1:0] wmask;
    alu_state_t        state_d;
    alu_state_t        state_q;

    assign op = alu_op_e'(opcode);

    alu_op2_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_op2 (
        .imm_sel (imm_sel),
        .reg_val (src2),
        .imm_val (imm8),
        .op2     (op2)
    );

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op   (op),
        .a    (src1),
        .b    (op2),
        .cin  (state_q.carry),
        .dw   (dst_w),
        .res  (au_res),
        .cout (au_cout)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op  (op),
        .a   (src1),
        .b   (op2),
        .res (lu_res)
    );

    always_comb begin
        case (dst_w)
            2'b00:   wmask = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            2'b01:   wmask = {{(DATA_W-MID_W){1'b0}}, {MID_W{1'b1}}};
            default: wmask = {DATA_W{1'b1}};
        endcase
        sel_res = is_arith(op) ? au_res : lu_res;
        result  = sel_res & wmask;
        state_d = state_q;
        if (op_valid && is_arith(op)) begin
            state_d.carry = au_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign carry = state_q.carry;

    a_r1_imm_zext: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel |-> op2[DATA_W-1:IMM_W] == '0);

    a_r10_narrow_trunc: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_w == 2'b00) |-> result[DATA_W-1:NARROW_W] == '0);

    a_r4_borrow_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SUB && dst_w[1]) |=> carry == ($past(src1) < $past(op2)));

    a_r8_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MIN) |-> (lu_res <= src1 && lu_res <= op2));

    a_r9_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BSET) |-> lu_res[op2[SH_W-1:0]]);

    a_r11_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !is_arith(op)) |=> $stable(carry));

    a_r12_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(carry));
endmodule

// File: tb/sim_cflag_alu.sv
module sim_cflag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        imm_sel = 1'b0;
    logic [31:0] src1 = '0;
    logic [31:0] src2 = '0;
    logic [7:0]  imm8 = '0;
    logic [1:0]  dst_w = '0;
    logic [31:0] result;
    logic        carry;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    logic  mc = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    cflag_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .imm_sel(imm_sel), .src1(src1), .src2(src2), .imm8(imm8),
        .dst_w(dst_w), .result(result), .carry(carry)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, int op, logic [31:0] a, logic [31:0] r2,
                         logic [7:0] im, logic isel, logic [1:0] dw, logic v);
        logic [63:0] b, s, m;
        int          w;
        logic [31:0] er;
        logic        ec;
        item_t       it;
        @(negedge clk);
        op_valid = v; opcode = 4'(op); src1 = a; src2 = r2;
        imm8 = im; imm_sel = isel; dst_w = dw;
        b = isel ? {56'd0, im} : {32'd0, r2};
        w = (dw == 2'd0) ? 8 : (dw == 2'd1) ? 16 : 32;
        m = (64'd1 << w) - 64'd1;
        ec = mc;
        case (op)
            0: s = {32'd0, a} + b;
            1: s = {32'd0, a} + b + {63'd0, mc};
            2: s = {32'd0, a} - b;
            3: s = {32'd0, a} - b - {63'd0, mc};
            4: s = b - {32'd0, a};
            5: s = b - {32'd0, a} - {63'd0, mc};
            6: s = {32'd0, a << b[4:0]};
            7: s = {32'd0, a >> b[4:0]};
            8: s = ({32'd0, a} < b) ? {32'd0, a} : b;
            9: s = ({32'd0, a} > b) ? {32'd0, a} : b;
            10: s = {32'd0, a & ~(32'd1 << b[4:0])};
            11: s = {32'd0, a | (32'd1 << b[4:0])};
            default: s = 64'd0;
        endcase
        er = 32'(s & m);
        if (v && op <= 5) ec = s[w];
        mc = ec;
        it.res = er; it.c = ec; it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                check({it.tag, " result"}, result, it.res);
                @(posedge clk);
                #1;
                check({it.tag, " carry"}, {31'd0, carry}, {31'd0, it.c});
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #1;
        check("R12 reset carry", {31'd0, carry}, 32'd0);
        rst_n = 1'b1;
        drive("R2 add wrap32", 0, 32'hFFFF_FFFF, 32'd1, 8'd0, 0, 2'd2, 1);
        drive("R3 adc cin1", 1, 32'd1, 32'd2, 8'd0, 0, 2'd2, 1);
        drive("R1 R10 add imm w8", 0, 32'hF0, 32'hDEAD, 8'h20, 1, 2'd0, 1);
        drive("R10 add w8 high bits", 0, 32'h1FF, 32'd1, 8'd0, 0, 2'd0, 1);
        drive("R4 sub borrow w16", 2, 32'd5, 32'd7, 8'd0, 0, 2'd1, 1);
        drive("R5 sbc w16", 3, 32'd10, 32'd3, 8'd0, 0, 2'd1, 1);
        drive("R4 sub equal", 2, 32'd7, 32'd7, 8'd0, 0, 2'd2, 1);
        drive("R4 sub borrow32", 2, 32'd0, 32'd1, 8'd0, 0, 2'd2, 1);
        drive("R5 sbc borrow in", 3, 32'd0, 32'd0, 8'd0, 0, 2'd2, 1);
        drive("R6 rsb", 4, 32'd3, 32'd10, 8'd0, 0, 2'd2, 1);
        drive("R6 rsb borrow", 4, 32'd10, 32'd3, 8'd0, 0, 2'd2, 1);
        drive("R6 rsc", 5, 32'd1, 32'd5, 8'd0, 0, 2'd2, 1);
        drive("R2 set carry", 0, 32'hFFFF_FFFF, 32'd1, 8'd0, 0, 2'd3, 1);
        drive("R7 R11 shl", 6, 32'd1, 32'h24, 8'd0, 0, 2'd2, 1);
        drive("R7 R11 shr imm", 7, 32'h8000_0000, 32'd0, 8'hFF, 1, 2'd2, 1);
        drive("R8 R11 min", 8, 32'd5, 32'hFFFF_FFFF, 8'd0, 0, 2'd2, 1);
        drive("R8 max", 9, 32'd5, 32'hFFFF_FFFF, 8'd0, 0, 2'd2, 1);
        drive("R8 R10 min w8", 8, 32'h100, 32'd3, 8'd0, 0, 2'd0, 1);
        drive("R9 bclr", 10, 32'hFFFF_FFFF, 32'd0, 8'h23, 1, 2'd2, 1);
        drive("R9 bset", 11, 32'd0, 32'h3F, 8'd0, 0, 2'd2, 1);
        drive("R9 R10 bset w8", 11, 32'd0, 32'd8, 8'd0, 0, 2'd0, 1);
        drive("R11 unused op", 13, 32'h1234, 32'h5678, 8'd0, 0, 2'd2, 1);
        drive("R3 adc w8 carry out", 1, 32'hFF, 32'd0, 8'd0, 0, 2'd0, 1);
        drive("R2 clear carry", 0, 32'd1, 32'd1, 8'd0, 0, 2'd2, 1);
        drive("R12 no strobe", 0, 32'hFFFF_FFFF, 32'd1, 8'd0, 0, 2'd2, 0);
        drive("R12 adc no strobe", 1, 32'd4, 32'd4, 8'd0, 0, 2'd2, 0);
        drive("R10 w16 trunc", 0, 32'h0001_FFFF, 32'd2, 8'd0, 0, 2'd1, 1);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule